// File: doc/BRIEF.md
# Bulk Erase Verify Sequencer

This controller sits on the host side of a byte-wide non-volatile array. It erases the whole array and confirms the erase. It drives a simple command port: a one-cycle write strobe with address and data, and a read strobe whose data returns one cycle later. After a start request it issues the erase setup command and the erase command (both 20h), then waits one erase pulse. Next it checks the array byte by byte, from address zero upward. For each byte it writes the erase-verify command A0h with that byte's address, waits a settling interval, and reads the byte back.

A byte passes only when it reads FFh. Any other value makes the controller apply one more erase pulse to the whole array. Checking then continues at the byte that failed, not at address zero. The whole run may use at most a fixed number of erase pulses. When the last address passes, the controller writes the read command 00h and raises done. If a byte still fails once the budget is spent, it raises error instead. The pulse length, the settling interval, the last address and the pulse budget are parameters counted in clock cycles. The default budget is 30 pulses.

Top module: `erase_verify_seq`

## Requirements
- R1: While reset is held and after it is released, busy, done, error, cmd_we and cmd_re are all low and no command is issued until start is seen.
- R2: A start seen while idle produces two writes of 20h on consecutive cycles, with no other command before them; every later erase pulse is issued the same way.
- R3: The first verify write after an erase write comes exactly PULSE_CYC+1 cycles after that erase write.
- R4: Each verify write carries data A0h and the address of the byte being checked. The read strobe follows exactly VWAIT_CYC+1 cycles later at the same address. The data on cmd_rdata in the cycle after the strobe is the value judged.
- R5: Within a run, the first byte checked is address 0. After a byte passes, the next byte checked is the following address, up to LAST_ADDR.
- R6: A byte passes only if it reads FFh. Any other value, including values that differ from FFh in a single bit, is followed directly by a new erase (two 20h writes).
- R7: After a re-erase, the next verify write uses the address of the byte that failed.
- R8: When LAST_ADDR reads FFh, the next command is a write of 00h, and done rises in the cycle after it.
- R9: A run issues at most MAX_PULSES erase pulses. A failing read when the budget is spent raises error, issues no further erase, and issues no 00h write. A byte that passes after exactly MAX_PULSES pulses still ends in done.
- R10: busy is high from the cycle after start until the run ends. done and error are never high together and stay high until the next start, which clears them. A start seen while busy has no effect.
- R11: cmd_we and cmd_re are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches an erase-and-verify run when idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run ended with every byte blank (sticky) |
| error | output | 1 | Pulse budget spent with a byte not blank (sticky) |
| cmd_we | output | 1 | One-cycle command write strobe |
| cmd_addr | output | ADDR_W | Command or read address |
| cmd_wdata | output | 8 | Command write data |
| cmd_re | output | 1 | One-cycle read strobe |
| cmd_rdata | input | 8 | Read data, valid the cycle after cmd_re |

## Verification
Two decisions can fall in the same cycle: a read can pass at the last address while the pulse budget is already spent. The bench provokes this with a byte at LAST_ADDR that needs exactly MAX_PULSES pulses, and checks that the result is done with the 00h write, not error. The opposite case uses a byte that needs one pulse more than the budget, and must end in error with no 00h write. A bench model of the array counts erase pulses and returns FFh only after each byte's required count. A sweep moves a slow byte across every address, so the resume address, the pulse count and the total number of reads can be checked against values computed from that profile.

// File: rtl/evs_pkg.sv
package evs_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [3:0] {
    S_IDLE, S_SETUP, S_ERASE, S_EWAIT, S_VCMD, S_VWAIT, S_RDREQ, S_RDCHK, S_RDCMD
  } evs_state_e;

  localparam logic [DATA_W-1:0] CMD_ERASE  = 8'h20;
  localparam logic [DATA_W-1:0] CMD_VERIFY = 8'hA0;
  localparam logic [DATA_W-1:0] CMD_READ   = 8'h00;
  localparam logic [DATA_W-1:0] BLANK_BYTE = 8'hFF;
endpackage

// File: rtl/evs_timer.sv
module evs_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                   cnt_d = load_val;
    else if (run && cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  // R3/R4: the wait counter only moves down between loads
  assert_timer_monotonic_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load) |-> cnt_q <= $past(cnt_q));
endmodule

// File: rtl/evs_pulse_ctr.sv
module evs_pulse_ctr #(
  parameter int MAX_PULSES = 30,
  localparam int PC_W = $clog2(MAX_PULSES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_max
);
  logic [PC_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign at_max = (cnt_q == PC_W'(MAX_PULSES));

  assert_pulse_budget_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= PC_W'(MAX_PULSES));
  assert_no_pulse_past_budget_R9: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> !at_max);
endmodule

// File: rtl/evs_addr_walk.sv
module evs_addr_walk #(
  parameter int ADDR_W    = 18,
  parameter int LAST_ADDR = 262143
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  output logic [ADDR_W-1:0] addr,
  output logic              at_last
);
  logic [ADDR_W-1:0] addr_q, addr_d;

  always_comb begin
    addr_d = addr_q;
    if (clr)      addr_d = '0;
    else if (adv) addr_d = addr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign addr    = addr_q;
  assign at_last = (addr_q == ADDR_W'(LAST_ADDR));

  assert_addr_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    addr_q <= ADDR_W'(LAST_ADDR));
  assert_no_step_past_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> !at_last);
endmodule

// File: rtl/erase_verify_seq.sv
module erase_verify_seq
  import evs_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int LAST_ADDR  = 262143,
  parameter int PULSE_CYC  = 10000000,
  parameter int VWAIT_CYC  = 600,
  parameter int MAX_PULSES = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              cmd_we,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [7:0]        cmd_wdata,
  output logic              cmd_re,
  input  logic [7:0]        cmd_rdata
);
  localparam int TMR_MAX = (PULSE_CYC > VWAIT_CYC) ? PULSE_CYC : VWAIT_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  evs_state_e        state_q, state_d;
  logic              done_q, err_q, done_set, err_set, flags_clr;
  logic              tmr_load, tmr_run, tmr_exp;
  logic [TMR_W-1:0]  tmr_val;
  logic              p_clr, p_inc, p_max;
  logic              a_clr, a_adv, a_last;
  logic [ADDR_W-1:0] cur_addr;

  evs_timer #(.CNT_W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .run(tmr_run), .expired(tmr_exp));

  evs_pulse_ctr #(.MAX_PULSES(MAX_PULSES)) u_pulses (
    .clk(clk), .rst_n(rst_n), .clr(p_clr), .inc(p_inc), .at_max(p_max));

  evs_addr_walk #(.ADDR_W(ADDR_W), .LAST_ADDR(LAST_ADDR)) u_addr (
    .clk(clk), .rst_n(rst_n), .clr(a_clr), .adv(a_adv),
    .addr(cur_addr), .at_last(a_last));

  always_comb begin
    state_d   = state_q;
    cmd_we    = 1'b0;
    cmd_re    = 1'b0;
    cmd_wdata = CMD_READ;
    cmd_addr  = '0;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    tmr_run   = 1'b0;
    p_clr     = 1'b0;
    p_inc     = 1'b0;
    a_clr     = 1'b0;
    a_adv     = 1'b0;
    done_set  = 1'b0;
    err_set   = 1'b0;
    flags_clr = 1'b0;
    unique case (state_q)
      S_IDLE: if (start) begin
        state_d   = S_SETUP;
        p_clr     = 1'b1;
        a_clr     = 1'b1;
        flags_clr = 1'b1;
      end
      S_SETUP: begin
        cmd_we    = 1'b1;
        cmd_wdata = CMD_ERASE;
        state_d   = S_ERASE;
      end
      S_ERASE: begin
        cmd_we    = 1'b1;
        cmd_wdata = CMD_ERASE;
        p_inc     = 1'b1;
        tmr_load  = 1'b1;
        tmr_val   = TMR_W'(PULSE_CYC - 1);
        state_d   = S_EWAIT;
      end
      S_EWAIT: begin
        tmr_run = 1'b1;
        if (tmr_exp) state_d = S_VCMD;
      end
      S_VCMD: begin
        cmd_we    = 1'b1;
        cmd_wdata = CMD_VERIFY;
        cmd_addr  = cur_addr;
        tmr_load  = 1'b1;
        tmr_val   = TMR_W'(VWAIT_CYC - 1);
        state_d   = S_VWAIT;
      end
      S_VWAIT: begin
        tmr_run = 1'b1;
        if (tmr_exp) state_d = S_RDREQ;
      end
      S_RDREQ: begin
        cmd_re   = 1'b1;
        cmd_addr = cur_addr;
        state_d  = S_RDCHK;
      end
      S_RDCHK: begin
        if (cmd_rdata == BLANK_BYTE) begin
          if (a_last) state_d = S_RDCMD;
          else begin
            a_adv   = 1'b1;
            state_d = S_VCMD;
          end
        end else if (p_max) begin
          err_set = 1'b1;
          state_d = S_IDLE;
        end else begin
          state_d = S_SETUP;
        end
      end
      S_RDCMD: begin
        cmd_we    = 1'b1;
        cmd_wdata = CMD_READ;
        done_set  = 1'b1;
        state_d   = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (flags_clr) begin
        done_q <= 1'b0;
        err_q  <= 1'b0;
      end else begin
        if (done_set) done_q <= 1'b1;
        if (err_set)  err_q  <= 1'b1;
      end
    end
  end

  assign busy  = (state_q != S_IDLE);
  assign done  = done_q;
  assign error = err_q;

  assert_single_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_we && cmd_re));
  assert_exclusive_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));
  assert_busy_hides_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!done && !error));
  assert_judge_after_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_RDCHK) |-> $past(cmd_re));
  assert_done_after_readcmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(cmd_we && cmd_wdata == CMD_READ));
  assert_error_at_budget_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> p_max);
endmodule

// File: tb/erase_verify_seq_tb.sv
`timescale 1ns/1ps
module erase_verify_seq_tb;
  localparam int ADDR_W = 18;
  localparam int LAST   = 15;
  localparam int NB     = LAST + 1;
  localparam int PULSE  = 20;
  localparam int VWAIT  = 3;
  localparam int MAXP   = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, error, cmd_we, cmd_re;
  logic [ADDR_W-1:0] cmd_addr;
  logic [7:0] cmd_wdata;
  logic [7:0] cmd_rdata;

  always #2 clk = ~clk;

  erase_verify_seq #(.ADDR_W(ADDR_W), .LAST_ADDR(LAST), .PULSE_CYC(PULSE),
    .VWAIT_CYC(VWAIT), .MAX_PULSES(MAXP)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .error(error),
    .cmd_we(cmd_we), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_re(cmd_re),
    .cmd_rdata(cmd_rdata));

  int n_checks = 0, n_fail = 0;
  int need [NB];
  int cyc = 0;
  int pulses = 0, reads = 0, readcmds = 0;
  int last_wcyc = -10, erase_cyc = -10, vcyc = -10, vaddr = 0, prev_vaddr = -1;
  int fail_addr = 0;
  bit prev20 = 0, first_v = 0, after_erase = 0, resume = 0, exp_erase = 0, exp_rcmd = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // array model: a byte reads FFh once it has seen its required pulse count
  always @(posedge clk)
    if (cmd_re)
      cmd_rdata <= (pulses >= need[cmd_addr[3:0]]) ? 8'hFF :
                   (cmd_addr[0] ? 8'h7F : 8'hFE);
    else
      cmd_rdata <= 8'h00;

  always @(posedge clk) cyc <= cyc + 1;

  // port monitor, sampled mid-cycle
  always @(negedge clk) if (rst_n) begin
    if (cmd_we && cmd_re) check(0, "R11", 1, 0);
    if (cmd_we) begin
      if (exp_erase) begin
        check(cmd_wdata == 8'h20, "R6", cmd_wdata, 8'h20);
        exp_erase = 0;
      end
      if (exp_rcmd) begin
        check(cmd_wdata == 8'h00, "R8", cmd_wdata, 0);
        exp_rcmd = 0;
      end
      if (cmd_wdata == 8'h20) begin
        if (prev20 && last_wcyc == cyc - 1) begin
          pulses++;
          erase_cyc = cyc;
          after_erase = 1;
          prev20 = 0;
        end else prev20 = 1;
      end else begin
        check(!prev20, "R2", cmd_wdata, 8'h20);
        prev20 = 0;
        if (cmd_wdata == 8'hA0) begin
          vaddr = int'(cmd_addr);
          vcyc = cyc;
          if (after_erase) check(cyc - erase_cyc == PULSE + 1, "R3", cyc - erase_cyc, PULSE + 1);
          after_erase = 0;
          if (first_v)     check(vaddr == 0, "R5", vaddr, 0);
          else if (resume) check(vaddr == fail_addr, "R7", vaddr, fail_addr);
          else             check(vaddr == prev_vaddr + 1, "R5", vaddr, prev_vaddr + 1);
          first_v = 0;
          resume = 0;
          prev_vaddr = vaddr;
        end else if (cmd_wdata == 8'h00) readcmds++;
      end
      last_wcyc = cyc;
    end
    if (cmd_re) begin
      reads++;
      check(cyc - vcyc == VWAIT + 1, "R4", cyc - vcyc, VWAIT + 1);
      check(int'(cmd_addr) == vaddr, "R4", int'(cmd_addr), vaddr);
      if (pulses < need[cmd_addr[3:0]]) begin
        fail_addr = int'(cmd_addr);
        resume = 1;
        if (pulses < MAXP) exp_erase = 1;
      end else if (int'(cmd_addr) == LAST) exp_rcmd = 1;
    end
  end

  task automatic run_case(input string tag, input bit exp_done, input int exp_pulses,
                          input int exp_reads, input bit poke);
    int waited = 0;
    pulses = 0; reads = 0; readcmds = 0; prev20 = 0; first_v = 1; after_erase = 0;
    resume = 0; exp_erase = 0; exp_rcmd = 0; prev_vaddr = -1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy && !done && !error, "R10", {busy, done, error}, 3'b100);
    @(negedge clk);
    check(cmd_we && cmd_wdata == 8'h20 && cmd_addr == '0, "R2", cmd_wdata, 8'h20);
    while (!(done || error) && waited < 5000) begin
      if (poke && waited == 50) start = 1'b1;
      if (poke && waited == 51) start = 1'b0;
      @(negedge clk);
      waited++;
    end
    check(waited < 5000, "watchdog", waited, 5000);
    check(done == exp_done && error == !exp_done, {tag, " R9"}, done, exp_done);
    check(pulses == exp_pulses, {tag, " R9"}, pulses, exp_pulses);
    check(reads == exp_reads, {tag, " R7"}, reads, exp_reads);
    check(readcmds == (exp_done ? 1 : 0), {tag, " R8"}, readcmds, exp_done);
    repeat (5) @(negedge clk);
    check(done == exp_done && error == !exp_done && !busy, {tag, " R10"}, done, exp_done);
  endtask

  initial begin
    for (int i = 0; i < NB; i++) need[i] = 1;
    repeat (3) @(negedge clk);
    check(!busy && !done && !error && !cmd_we && !cmd_re, "R1", busy, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !done && !error && !cmd_we && !cmd_re, "R1", busy, 0);

    // single pulse erases everything
    run_case("blank", 1, 1, NB, 0);
    // slow byte swept over every address, 2..6 pulses
    for (int a = 0; a < NB; a++) begin
      for (int i = 0; i < NB; i++) need[i] = 1;
      need[a] = 2 + (a % 5);
      run_case("sweep", 1, need[a], NB + need[a] - 1, 0);
    end
    // several slow bytes, start pulsed while busy (R10 no effect)
    for (int i = 0; i < NB; i++) need[i] = (i * 7) % 4;
    run_case("multi R10", 1, 3, NB + 2, 1);
    // last byte needs exactly the budget: done wins (R9)
    for (int i = 0; i < NB; i++) need[i] = 1;
    need[LAST] = MAXP;
    run_case("edge", 1, MAXP, NB + MAXP - 1, 0);
    // one pulse beyond budget at address 6: error
    need[LAST] = 1;
    need[6] = MAXP + 1;
    run_case("over", 0, MAXP, 6 + MAXP, 0);
    // recovery run after error clears flags
    need[6] = 1;
    run_case("again", 1, 1, NB, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #700000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule